// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and steers each one onto one of 15 output interrupt lines. Every source has its own enable bit and its own 4-bit destination code; an output line is high whenever at least one enabled, asserted source whose code selects that line is high. There is no edge capture and no latching: the outputs follow the request inputs through combinational logic, and only the configuration is held in flops.

Software drives a plain 32-bit register port with a byte address, write strobe, write data and combinational read data. It clears all enables first, programs the destination codes, then opens the enables it wants. When servicing an output line, software reads the live request levels and ANDs them with its enable word to find which sources are pending.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every enable bit and every destination code is zero, all outputs are low, and the enable and routing registers read back as zero.
- R2: The enable register is at byte address 0x00. Bit n enables source n. It reads back the last value written.
- R3: The register at 0x04 returns the raw request levels (bit n = source n) whether or not the sources are enabled. Writes to 0x04 change no register and no output.
- R4: Four routing words sit at 0x08, 0x0C, 0x10 and 0x14. The word at 0x14 holds sources 0 to 7, 0x10 holds 8 to 15, 0x0C holds 16 to 23 and 0x08 holds 24 to 31. Source n uses bits [4*(n%8)+3 : 4*(n%8)] of its word. Each word reads back what was written.
- R5: A source whose destination code is 0 drives no output, even when it is enabled and high.
- R6: A destination code k in the range 1 to 15 sends the source to output line k-1. This includes code 15 to line 14.
- R7: Each output is the OR of all sources that are enabled, high and coded for it. It tracks the inputs level by level in the same cycle, with nothing held.
- R8: Reads of any other byte address, including addresses not aligned to a word, return zero. Writes to such addresses change nothing.
- R9: A register write takes effect at the clock edge where the strobe is sampled. The outputs and read data show the new setting in the cycle after that edge.
- R10: A source whose enable bit is clear has no effect on any output, whatever its code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| irq_out | output | 15 | Routed interrupt output lines |

## Verification
The hardest case to reach is several sources sharing one output line while only some of them are enabled, set against sources with code 0 or code 15. A short run of directed writes will not build that mix. The stimulus therefore writes random values into the enable word and into all four routing words, so many sources land on the same few lines. It then applies random request patterns and compares each output line with a bench model. Directed steps cover the reversed word order, code 0, code 15, and writes to the status address and to unmapped addresses.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int SRC_N  = 32,
  parameter int OUT_N  = 15,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SRC_N-1:0]  irq_in,
  output logic [OUT_N-1:0]  irq_out
);
  localparam int PER_WORD = DATA_W / CODE_W;
  localparam int WORDS    = SRC_N / PER_WORD;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(4);
  localparam int                A_RT0 = 8;

  logic [SRC_N-1:0]  en_q;
  logic [CODE_W-1:0] code_q [SRC_N];
  logic [SRC_N-1:0]  hit [OUT_N];

  // routing word w holds sources starting at (WORDS-1-w)*PER_WORD
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int s = 0; s < SRC_N; s++) code_q[s] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_EN) en_q <= reg_wdata[SRC_N-1:0];
      for (int w = 0; w < WORDS; w++)
        if (reg_addr == ADDR_W'(A_RT0 + 4*w))
          for (int j = 0; j < PER_WORD; j++)
            code_q[(WORDS-1-w)*PER_WORD + j] <= reg_wdata[j*CODE_W +: CODE_W];
    end
  end

  genvar o, s;
  generate
    for (o = 0; o < OUT_N; o++) begin : g_out
      for (s = 0; s < SRC_N; s++) begin : g_src
        assign hit[o][s] = (code_q[s] == CODE_W'(o + 1));
      end
      assign irq_out[o] = |(irq_in & en_q & hit[o]);
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_EN) reg_rdata = DATA_W'(en_q);
    if (reg_addr == A_ST) reg_rdata = DATA_W'(irq_in);
    for (int w = 0; w < WORDS; w++)
      if (reg_addr == ADDR_W'(A_RT0 + 4*w))
        for (int j = 0; j < PER_WORD; j++)
          reg_rdata[j*CODE_W +: CODE_W] = code_q[(WORDS-1-w)*PER_WORD + j];
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int SRC_N  = 32,
  parameter int OUT_N  = 15,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [SRC_N-1:0]  irq_in,
  input logic [OUT_N-1:0]  irq_out,
  input logic [SRC_N-1:0]  en_q
);
  logic unmapped;
  assign unmapped = (reg_addr > ADDR_W'(20)) || (reg_addr[1:0] != 2'b00);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == '0 && en_q == '0));

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> en_q == $past(reg_wdata[SRC_N-1:0]));

  a_r2_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(0)) |=> $stable(en_q));

  a_r3_status_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(4)) |-> reg_rdata == DATA_W'(irq_in));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> reg_rdata == '0);

  a_r10_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ((irq_in & en_q) != '0));
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .SRC_N(SRC_N), .OUT_N(OUT_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
  .irq_out(irq_out), .en_q(en_q)
);

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_in = '0;
  logic [14:0] irq_out;

  int tests = 0, fails = 0;
  logic [31:0] en_m;
  logic [3:0]  rt_m [32];

  always #5 clk = ~clk;

  irq_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .irq_out(irq_out)
  );

  function automatic logic [14:0] exp_out(input logic [31:0] in);
    logic [14:0] r = '0;
    for (int s = 0; s < 32; s++)
      if (in[s] && en_m[s] && rt_m[s] != 4'd0) r[rt_m[s] - 4'd1] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r = en_m;
    else if (a == 8'h04) r = irq_in;
    else if (a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00) begin
      int base;
      base = (8'h14 - a) * 2;  // 0x14 -> 0, 0x10 -> 8, 0x0C -> 16, 0x08 -> 24
      for (int j = 0; j < 8; j++) r[4*j +: 4] = rt_m[base + j];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h00) en_m = d;
    else if (a >= 8'h08 && a <= 8'h14 && a[1:0] == 2'b00) begin
      int base;
      base = (8'h14 - a) * 2;
      for (int j = 0; j < 8; j++) rt_m[base + j] = d[4*j +: 4];
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  task automatic out_chk(input string tag, input logic [31:0] in);
    irq_in = in; #1;
    chk(tag, {17'd0, irq_out}, {17'd0, exp_out(in)});
  endtask

  task automatic all_regs(input string tag);
    for (int a = 0; a <= 20; a += 4) rd_chk(tag, 8'(a));
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    en_m = '0;
    for (int s = 0; s < 32; s++) rt_m[s] = '0;
    irq_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    out_chk("R1 reset outputs", 32'hFFFF_FFFF);
    all_regs("R1 reset regs");

    // R4: reversed word order, source 0 in 0x14, source 31 in 0x08 top nibble
    wr(8'h14, 32'h0000_0001);
    wr(8'h08, 32'hF000_0000);
    all_regs("R4 word order");
    // R9/R10: code set but disabled -> quiet
    out_chk("R10 disabled source", 32'h8000_0001);
    wr(8'h00, 32'h8000_0001);
    // R6: code 1 -> line 0, code 15 -> line 14
    out_chk("R6 code1 line0", 32'h0000_0001);
    out_chk("R6 code15 line14", 32'h8000_0000);
    chk("R6 line14 bit", {31'd0, irq_out[14]}, 32'd1);
    // R7: level follows, drops with input
    out_chk("R7 level drop", 32'h0000_0000);
    // R5: enabled, high, code 0
    wr(8'h00, 32'hFFFF_FFFF);
    out_chk("R5 code0 quiet", 32'h0000_0002);
    // R3: status raw, writes ignored
    irq_in = 32'hA5A5_0F0F;
    wr(8'h04, 32'h1234_5678);
    rd_chk("R3 status raw", 8'h04);
    all_regs("R3 status write ignored");
    // R8: unmapped
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    all_regs("R8 unmapped write ignored");
    reg_addr = 8'h18; #1; chk("R8 unmapped read", reg_rdata, 32'd0);
    reg_addr = 8'h09; #1; chk("R8 unaligned read", reg_rdata, 32'd0);
    reg_addr = 8'hFC; #1; chk("R8 high read", reg_rdata, 32'd0);

    // R9: new value visible only after edge
    @(negedge clk);
    reg_addr = 8'h00; reg_wdata = 32'h0; reg_wr = 1'b1; #1;
    chk("R9 before edge", reg_rdata, en_m);
    @(negedge clk); reg_wr = 1'b0; en_m = '0; #1;
    chk("R9 after edge", reg_rdata, 32'd0);

    // R2/R4/R7 random
    for (int i = 0; i < 400; i++) begin
      int pick;
      logic [31:0] d;
      pick = $urandom_range(0, 6);
      d = $urandom;
      case (pick)
        0: wr(8'h00, d);
        1: wr(8'h08, d);
        2: wr(8'h0C, d);
        3: wr(8'h10, d);
        4: wr(8'h14, d);
        5: wr(8'h04, d);
        default: wr(8'(($urandom_range(0, 63) * 4) + 1), d);
      endcase
      out_chk("R7 random out", $urandom);
      rd_chk("R2 R4 random read", 8'($urandom_range(0, 5) * 4));
    end

    // R1 again: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    en_m = '0;
    for (int s = 0; s < 32; s++) rt_m[s] = '0;
    @(negedge clk); rst_n = 1'b1;
    out_chk("R1 reset again", 32'hFFFF_FFFF);
    all_regs("R1 reset again regs");
    finish_run();
  end
endmodule